// File: doc/BRIEF.md
# Reference-Based Frequency Lock Detector

This block supervises a clock recovery loop. It compares the frequency of the recovered clock, already divided down, against a local reference clock. The nominal ratio between the two is fixed at 20. Over a window of a fixed number of reference cycles it counts recovered-clock edges. It then checks whether that count lies within a chosen ppm tolerance of the expected value.

The verdict drives two outputs. The path-select output tells the loop which detector to follow. While the frequency is off, the loop follows the reference phase-frequency comparator. Once a window measures in range, the loop goes back to the data phase detector. The lock alarm rises only after a run of consecutive good windows. A single bad window clears it at once. Measurement never stops, so a locked loop that drifts is caught at the next window boundary.

The count from the recovered-clock domain crosses into the reference domain as a Gray code. Every decision is made in the reference domain.

Top module: `freq_lock_det`

## Requirements
- R1: While `rst_n` is low, `lock_alarm` is 0 and `path_sel_ref` is 1 (1 selects the reference comparator, 0 selects the data phase detector).
- R2: A window lasts `WIN_CYCLES` reference cycles. Over each window the recovered-clock count is compared with `RATIO*WIN_CYCLES`. The allowed deviation is floor(`RATIO*WIN_CYCLES*ppm/1000000`). The first window after reset only records a baseline and yields no verdict.
- R3: `tol_wide` = 0 selects the narrow tolerance (default 500 ppm). `tol_wide` = 1 selects the wide tolerance (default 2000 ppm). The setting is sampled at each window end.
- R4: After an in-range window, `path_sel_ref` is 0 from the first cycle after that window end. Whenever `lock_alarm` is 1, `path_sel_ref` is 0.
- R5: `lock_alarm` rises only after `GOOD_WINS` (default 2) consecutive in-range windows. With steady in-range input, it therefore rises exactly one window after `path_sel_ref` falls.
- R6: After an out-of-range window, `lock_alarm` falls to 0 and `path_sel_ref` rises to 1 in the same cycle, from the first cycle after that window end.
- R7: The outputs change only on the clock edge that closes a window. With reset released, a change is seen only at edges numbered a multiple of `WIN_CYCLES`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Local reference clock; all decisions are made in this domain |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| rec_clk | input | 1 | Recovered clock after the divider, nominally RATIO times ref_clk |
| tol_wide | input | 1 | Tolerance select: 0 narrow, 1 wide |
| lock_alarm | output | 1 | Frequency lock indication and alarm |
| path_sel_ref | output | 1 | Loop source: 1 reference comparator, 0 data phase detector |

## Verification
On every cycle, the assertions check several properties of the outputs. Window ends must come exactly `WIN_CYCLES` apart, and no verdict may come from the baseline window. The outputs may move only on a window end. A bad verdict must drop lock and select the reference path on the next cycle. A good verdict must select the data path. Lock may rise only when the data path was already selected and the good-window streak has reached its threshold.

Some behaviours depend on real clock frequencies, and only the bench scenarios can show them. One is whether a given ppm offset is judged in or out of range under each tolerance setting. Another is that a real recovered-clock count, carried across the clock domains, lands on the expected side of the limit. The bench sweeps signed offsets under both tolerances. It also measures the one-window gap between path release and lock, and it checks the same-cycle drop on loss.

// File: rtl/freq_lock_pkg.sv
`timescale 1ns/1ps
package freq_lock_pkg;

  // Allowed count deviation for a nominal count and a tolerance in ppm (floor).
  function automatic logic [63:0] dev_limit(input logic [63:0] nominal, input logic [31:0] ppm);
    return (nominal * 64'(ppm)) / 64'd1000000;
  endfunction

  function automatic logic [63:0] abs_diff(input logic [63:0] a, input logic [63:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  typedef enum logic {
    SRC_DATA = 1'b0,
    SRC_REF  = 1'b1
  } loop_src_e;

endpackage

// File: rtl/fld_rec_count.sv
`timescale 1ns/1ps
module fld_rec_count #(
  parameter int CW = 19
) (
  input  logic          rec_clk,
  input  logic          rst_n,
  output logic [CW-1:0] gray_o
);
  logic [CW-1:0] bin_q;
  logic [CW-1:0] bin_nx;

  assign bin_nx = bin_q + CW'(1);

  always_ff @(posedge rec_clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= bin_nx;
      gray_o <= bin_nx ^ (bin_nx >> 1);
    end
  end
endmodule

// File: rtl/fld_gray_sync.sv
`timescale 1ns/1ps
module fld_gray_sync #(
  parameter int CW     = 19,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] gray_i,
  output logic [CW-1:0] bin_o
);
  logic [CW-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= gray_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  always_comb begin
    logic [CW-1:0] b;
    b[CW-1] = stg_q[STAGES-1][CW-1];
    for (int i = CW - 2; i >= 0; i--) b[i] = b[i+1] ^ stg_q[STAGES-1][i];
    bin_o = b;
  end
endmodule

// File: rtl/fld_window.sv
`timescale 1ns/1ps
module fld_window #(
  parameter int WIN_CYCLES = 4096,
  parameter int CW         = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  output logic          win_end,
  output logic          meas_stb,
  output logic [CW-1:0] delta
);
  localparam int WW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;

  logic [WW-1:0] wcnt_q;
  logic [CW-1:0] base_q;
  logic          primed_q;

  assign win_end  = (wcnt_q == WW'(WIN_CYCLES - 1));
  assign meas_stb = win_end && primed_q;
  assign delta    = cnt_i - base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q   <= '0;
      base_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      wcnt_q <= win_end ? '0 : wcnt_q + WW'(1);
      if (win_end) begin
        base_q   <= cnt_i;
        primed_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fld_lock_ctl.sv
`timescale 1ns/1ps
module fld_lock_ctl
  import freq_lock_pkg::*;
#(
  parameter int CW         = 19,
  parameter int EXP_CNT    = 81920,
  parameter int NARROW_PPM = 500,
  parameter int WIDE_PPM   = 2000,
  parameter int GOOD_WINS  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          meas_stb,
  input  logic [CW-1:0] delta,
  input  logic          tol_wide,
  output logic          in_range,
  output logic          lock,
  output logic          sel_ref
);
  localparam logic [63:0] EXP64 = 64'(EXP_CNT);
  localparam logic [63:0] LIM_N = dev_limit(EXP64, 32'(NARROW_PPM));
  localparam logic [63:0] LIM_W = dev_limit(EXP64, 32'(WIDE_PPM));
  localparam int          GCW   = $clog2(GOOD_WINS + 1);

  logic [GCW-1:0] good_q;
  logic [GCW-1:0] good_nx;
  loop_src_e      src_q;

  assign in_range = abs_diff(64'(delta), EXP64) <= (tol_wide ? LIM_W : LIM_N);
  assign good_nx  = (good_q >= GCW'(GOOD_WINS)) ? good_q : good_q + GCW'(1);
  assign sel_ref  = (src_q == SRC_REF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= '0;
      lock   <= 1'b0;
      src_q  <= SRC_REF;
    end else if (meas_stb) begin
      if (in_range) begin
        good_q <= good_nx;
        lock   <= (good_nx >= GCW'(GOOD_WINS));
        src_q  <= SRC_DATA;
      end else begin
        good_q <= '0;
        lock   <= 1'b0;
        src_q  <= SRC_REF;
      end
    end
  end
endmodule

// File: rtl/freq_lock_det.sv
`timescale 1ns/1ps
module freq_lock_det #(
  parameter int WIN_CYCLES  = 4096,
  parameter int RATIO       = 20,
  parameter int NARROW_PPM  = 500,
  parameter int WIDE_PPM    = 2000,
  parameter int GOOD_WINS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic rec_clk,
  input  logic tol_wide,
  output logic lock_alarm,
  output logic path_sel_ref
);
  localparam int EXP_CNT = RATIO * WIN_CYCLES;
  localparam int CW      = $clog2(EXP_CNT) + 2;

  logic [CW-1:0] rec_gray;
  logic [CW-1:0] ref_bin;
  logic [CW-1:0] delta;
  logic          win_end;
  logic          meas_stb;
  logic          in_range;

  fld_rec_count #(.CW(CW)) u_cnt (
    .rec_clk (rec_clk),
    .rst_n   (rst_n),
    .gray_o  (rec_gray)
  );

  fld_gray_sync #(.CW(CW), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (ref_clk),
    .rst_n  (rst_n),
    .gray_i (rec_gray),
    .bin_o  (ref_bin)
  );

  fld_window #(.WIN_CYCLES(WIN_CYCLES), .CW(CW)) u_win (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .cnt_i    (ref_bin),
    .win_end  (win_end),
    .meas_stb (meas_stb),
    .delta    (delta)
  );

  fld_lock_ctl #(
    .CW(CW), .EXP_CNT(EXP_CNT), .NARROW_PPM(NARROW_PPM),
    .WIDE_PPM(WIDE_PPM), .GOOD_WINS(GOOD_WINS)
  ) u_ctl (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .meas_stb (meas_stb),
    .delta    (delta),
    .tol_wide (tol_wide),
    .in_range (in_range),
    .lock     (lock_alarm),
    .sel_ref  (path_sel_ref)
  );
endmodule

// File: rtl/freq_lock_det_chk.sv
`timescale 1ns/1ps
module freq_lock_det_chk #(
  parameter int WIN_CYCLES = 4096,
  parameter int GOOD_WINS  = 2
) (
  input logic clk,
  input logic rst_n,
  input logic win_end,
  input logic meas_stb,
  input logic in_range,
  input logic lock,
  input logic sel_ref
);
  int   gap_q;
  int   streak_q;
  logic seen_end_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q      <= 0;
      streak_q   <= 0;
      seen_end_q <= 1'b0;
    end else begin
      gap_q <= win_end ? 0 : gap_q + 1;
      if (win_end) seen_end_q <= 1'b1;
      if (meas_stb) streak_q <= in_range ? streak_q + 1 : 0;
    end
  end

  AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |-> gap_q == WIN_CYCLES - 1); // R2
  AST_BASELINE_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    meas_stb |-> seen_end_q); // R2
  AST_DATA_PATH_ON_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    meas_stb && in_range |=> !sel_ref); // R4
  AST_LOCK_IMPLIES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> !sel_ref); // R4
  AST_LOCK_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(!sel_ref)); // R5
  AST_LOCK_STREAK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> streak_q >= GOOD_WINS); // R5
  AST_DROP_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    meas_stb && !in_range |=> !lock && sel_ref); // R6
  AST_QUIET_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(lock) && $stable(sel_ref)); // R7
endmodule

bind freq_lock_det freq_lock_det_chk #(
  .WIN_CYCLES(WIN_CYCLES), .GOOD_WINS(GOOD_WINS)
) u_chk (
  .clk      (ref_clk),
  .rst_n    (rst_n),
  .win_end  (win_end),
  .meas_stb (meas_stb),
  .in_range (in_range),
  .lock     (lock_alarm),
  .sel_ref  (path_sel_ref)
);

// File: tb/freq_lock_det_tb_top.sv
`timescale 1ns/1ps
module freq_lock_det_tb_top;
  localparam int WIN   = 1024;
  localparam int RATIO = 20;
  localparam int NARP  = 500;
  localparam int WIDP  = 2000;

  logic ref_clk  = 1'b0;
  logic rec_clk  = 1'b0;
  logic rst_n    = 1'b0;
  logic tol_wide = 1'b0;
  logic lock_alarm;
  logic path_sel_ref;

  real ppm_now = 0.0;
  int  cyc = 0;
  int  n_run = 0;
  int  n_fail = 0;
  int  r7_bad = 0;
  int  sel_fall_at = -1, lock_rise_at = -1, sel_rise_at = -1, lock_fall_at = -1;
  logic prev_lock = 1'b0, prev_sel = 1'b1;
  bit  done = 1'b0;

  freq_lock_det #(
    .WIN_CYCLES(WIN), .RATIO(RATIO), .NARROW_PPM(NARP), .WIDE_PPM(WIDP),
    .GOOD_WINS(2), .SYNC_STAGES(2)
  ) dut_i (
    .ref_clk      (ref_clk),
    .rst_n        (rst_n),
    .rec_clk      (rec_clk),
    .tol_wide     (tol_wide),
    .lock_alarm   (lock_alarm),
    .path_sel_ref (path_sel_ref)
  );

  always #4 ref_clk = ~ref_clk;

  // Recovered clock: nominal 20x ref, offset by ppm_now, edges dithered to 1 ps.
  initial begin
    real    acc = 0.0;
    longint prv = 0;
    longint nxt;
    forever begin
      acc += 200.0 * 1.0e6 / (1.0e6 + ppm_now);
      nxt = longint'(acc);
      #(real'(nxt - prv) / 1000.0);
      prv = nxt;
      rec_clk = ~rec_clk;
    end
  end

  always @(posedge ref_clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // Output change monitor, sampled away from the active edge.
  always @(negedge ref_clk) begin
    if (rst_n) begin
      if ((lock_alarm != prev_lock || path_sel_ref != prev_sel) && (cyc % WIN) != 0)
        r7_bad++;
      if (prev_sel && !path_sel_ref)   sel_fall_at  = cyc;
      if (!prev_sel && path_sel_ref)   sel_rise_at  = cyc;
      if (!prev_lock && lock_alarm)    lock_rise_at = cyc;
      if (prev_lock && !lock_alarm)    lock_fall_at = cyc;
    end
    prev_lock = lock_alarm;
    prev_sel  = path_sel_ref;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    while (cyc != n) @(negedge ref_clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8.0 * 190000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int ppm_list [7] = '{0, 300, -300, 1000, -1000, 3000, -3000};
    repeat (10) @(negedge ref_clk);
    check(lock_alarm == 1'b0,   "R1 lock in reset",   lock_alarm,   0);
    check(path_sel_ref == 1'b1, "R1 select in reset", path_sel_ref, 1);
    rst_n = 1'b1;

    // R2: baseline window gives no verdict; R4/R5 first good windows.
    wait_cyc(2 * WIN - 1);
    check(path_sel_ref == 1'b1, "R2 baseline window no verdict", path_sel_ref, 1);
    wait_cyc(2 * WIN);
    check(path_sel_ref == 1'b0, "R4 data path after first good window", path_sel_ref, 0);
    check(lock_alarm == 1'b0,   "R5 no lock after one good window", lock_alarm, 0);
    wait_cyc(3 * WIN - 1);
    check(lock_alarm == 1'b0,   "R5 lock not early", lock_alarm, 0);
    wait_cyc(3 * WIN);
    check(lock_alarm == 1'b1,   "R5 lock after two good windows", lock_alarm, 1);

    // R3 sweep: both tolerances, signed offsets.
    for (int t = 0; t < 2; t++) begin
      for (int k = 0; k < 7; k++) begin
        int  tol_ppm;
        int  lim;
        real dev;
        bit  good;
        tol_wide = (t == 1);
        ppm_now  = real'(ppm_list[k]);
        repeat (4 * WIN) @(negedge ref_clk);
        tol_ppm = (t == 1) ? WIDP : NARP;
        lim  = (RATIO * WIN * tol_ppm) / 1000000;
        dev  = real'(RATIO * WIN) * ((ppm_list[k] < 0) ? -ppm_list[k] : ppm_list[k]) / 1.0e6;
        good = (dev <= real'(lim));
        check(lock_alarm == good,    $sformatf("R3 lock tol=%0d ppm=%0d", tol_ppm, ppm_list[k]),
              lock_alarm, good);
        check(path_sel_ref == !good, $sformatf("R3 select tol=%0d ppm=%0d", tol_ppm, ppm_list[k]),
              path_sel_ref, !good);
      end
    end

    // R5: recovery from out-of-range, lock one window after data path.
    tol_wide = 1'b0;
    ppm_now  = 3000.0;
    repeat (4 * WIN) @(negedge ref_clk);
    check(lock_alarm == 1'b0, "R6 lock lost at 3000 ppm", lock_alarm, 0);
    begin
      int t0 = cyc;
      ppm_now = 0.0;
      repeat (5 * WIN) @(negedge ref_clk);
      check(sel_fall_at > t0, "R4 data path regained", sel_fall_at, t0 + 1);
      check(lock_rise_at - sel_fall_at == WIN, "R5 lock one window after data path",
            lock_rise_at - sel_fall_at, WIN);
    end

    // R6: loss while locked drops lock and selects reference together.
    begin
      int t1 = cyc;
      ppm_now = -3000.0;
      repeat (4 * WIN) @(negedge ref_clk);
      check(lock_fall_at > t1, "R6 lock dropped", lock_fall_at, t1 + 1);
      check(lock_fall_at == sel_rise_at, "R6 same-cycle drop and reselect",
            lock_fall_at, sel_rise_at);
      check(path_sel_ref == 1'b1, "R6 reference path selected", path_sel_ref, 1);
    end

    check(r7_bad == 0, "R7 outputs change only at window ends", r7_bad, 0);
    finish_run();
  end
endmodule